// File: doc/BRIEF.md
# Extended-Range Phase Quantiser with Cycle Counter

This block turns the tap states of a ring-oscillator phase detector into a wide binary result. The fine phase arrives as a unary word of `TAPS` lines. It is converted to a binary level of `FINE_W` bits by counting its ones. A signed cycle counter of `CNT_W` bits extends the range above the fine bits. Each time the phase passes beyond its top level the counter steps up, and each time it passes below its bottom level the counter steps down. The counter saturates at its limits.

A wrap is not found by comparing consecutive samples. A phase-change strobe is gated with two level detectors, one that sees every tap high and one that sees every tap low. Several wraps may happen between two output samples, and each one is counted. The event logic runs on a fast clock. The sample strobe starts a short blanking window. While the window is open the counter holds still, and events that arrive in it are held back and applied together in the first cycle after it closes. On each sample strobe the block registers the word {counter, fine level}, and a valid pulse follows one cycle later.

Top module: `pq_extended_quant`

## Requirements
- R1: An active-high synchronous reset sets `code` to 0, drops `code_vld`, and clears the cycle counter to 0.
- R2: When `taps` is a proper thermometer word (bits 0 up to k-1 set, all others clear), `code[3:0]` reports k after a sample.
- R3: When `taps` holds a bubble (it is not a thermometer word), `code[3:0]` reports one plus the index of its highest set bit, or 0 when no bit is set.
- R4: In a cycle outside the blanking window where `phase_evt` is high and every tap is high, the counter rises by one.
- R5: In a cycle outside the blanking window where `phase_evt` is high and every tap is low, the counter falls by one.
- R6: Nothing changes the counter unless `phase_evt` is high and the taps are all high or all low. A strobe with mixed taps has no effect, and all-high or all-low taps without a strobe have no effect.
- R7: Events in consecutive fast cycles are each counted, with no limit on how many fall between two samples.
- R8: The counter is two's complement in `code[8:4]`. It stops at +15 and at -16 and never wraps.
- R9: `code` changes only at the edge that ends a cycle with `sample` high, and it holds its value between samples. `code_vld` is high for exactly the one cycle after each sample cycle.
- R10: The blanking window covers the sample cycle and the `BLANK_CYC` cycles after it, and the counter holds still throughout. Each event seen inside the window is deferred and added in the first cycle after the window, and a sample taken in that window reports the count from before the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast event clock |
| rst | input | 1 | Synchronous reset, active high |
| taps | input | 15 | Unary fine-phase word from the oscillator taps, bit 0 lowest |
| phase_evt | input | 1 | Phase-change strobe from the XOR detector |
| sample | input | 1 | Output sample strobe, one fast cycle wide |
| code | output | 9 | Registered result {counter[4:0], fine[3:0]} |
| code_vld | output | 1 | High for the cycle after a sample strobe |

## Verification
The hardest case to reach from the ports is an event that lands inside the blanking window. A late or early count shows up only through a later sample, and that sample must not start a new window that hides the result again. The stimulus fires an all-high event in the same cycle as a sample strobe and a second one in the cycle after it. It then samples again at once, inside the chained window, and expects the old count. After a few idle cycles a further sample must show both deferred steps. Saturation is reached by long bursts of events in consecutive cycles. A single opposite step then shows that the counter stayed at its limit and did not wrap.

// File: rtl/pq_pkg.sv
package pq_pkg;

    // Default geometry of the quantiser
    localparam int DEF_TAPS      = 15;
    localparam int DEF_CNT_W     = 5;
    localparam int DEF_BLANK_CYC = 1;

    // Classified wrap event of one fast cycle
    typedef enum logic [1:0] {
        WRAP_NONE = 2'b00,
        WRAP_UP   = 2'b01,
        WRAP_DN   = 2'b10
    } wrap_e;

    // Level detector results that feed the classifier
    typedef struct packed {
        logic all_hi;
        logic all_lo;
    } level_t;

    // Signed unit step for an event
    function automatic int wrap_step(input wrap_e ev);
        case (ev)
            WRAP_UP: return 1;
            WRAP_DN: return -1;
            default: return 0;
        endcase
    endfunction

    // Clamp an integer into a signed range
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/pq_therm_dec.sv
module pq_therm_dec
    import pq_pkg::*;
#(
    parameter int TAPS   = DEF_TAPS,
    parameter int FINE_W = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0]   taps,
    output logic [FINE_W-1:0] fine
);

    logic [FINE_W-1:0] ones;
    logic [FINE_W-1:0] top;
    logic              is_therm;

    // Population count and highest-set position
    always_comb begin
        ones = '0;
        top  = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + FINE_W'(taps[i]);
            if (taps[i]) top = FINE_W'(i + 1);
        end
    end

    // Thermometer shape: every bit below the count set, every bit above clear
    always_comb begin
        is_therm = 1'b1;
        for (int i = 0; i < TAPS; i++) begin
            if (taps[i] != (FINE_W'(i) < ones)) is_therm = 1'b0;
        end
    end

    assign fine = is_therm ? ones : top;

endmodule

// File: rtl/pq_wrap_detect.sv
module pq_wrap_detect
    import pq_pkg::*;
#(
    parameter int TAPS = DEF_TAPS
) (
    input  logic [TAPS-1:0] taps,
    input  logic            phase_evt,
    output wrap_e           ev
);

    level_t lvl;

    assign lvl.all_hi = &taps;
    assign lvl.all_lo = ~|taps;

    always_comb begin
        ev = WRAP_NONE;
        if (phase_evt) begin
            if (lvl.all_hi)      ev = WRAP_UP;
            else if (lvl.all_lo) ev = WRAP_DN;
        end
    end

endmodule

// File: rtl/pq_blank_gate.sv
module pq_blank_gate
    import pq_pkg::*;
#(
    parameter int BLANK_CYC = DEF_BLANK_CYC,
    parameter int DW        = $clog2(BLANK_CYC + 3) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample,
    input  wrap_e                ev,
    output logic                 apply,
    output logic signed [DW-1:0] delta
);

    localparam int WIN_W = (BLANK_CYC > 0) ? $clog2(BLANK_CYC + 1) : 1;
    localparam int PMAX  = (1 << (DW - 1)) - 1;
    localparam int PMIN  = -(1 << (DW - 1));

    logic                 blank;
    logic signed [DW-1:0] pend;
    int                   sum_i;

    generate
        if (BLANK_CYC > 0) begin : g_win
            logic [WIN_W-1:0] win;
            always_ff @(posedge clk) begin
                if (rst)              win <= '0;
                else if (sample)      win <= WIN_W'(BLANK_CYC);
                else if (win != '0)   win <= win - 1'b1;
            end
            assign blank = sample | (win != '0);
        end else begin : g_nowin
            assign blank = sample;
        end
    endgenerate

    // Held-back events plus the event of this cycle
    assign sum_i = clamp_int(int'(pend) + wrap_step(ev), PMIN, PMAX);

    always_ff @(posedge clk) begin
        if (rst)        pend <= '0;
        else if (blank) pend <= DW'(sum_i);
        else            pend <= '0;
    end

    assign apply = ~blank;
    assign delta = blank ? '0 : DW'(sum_i);

endmodule

// File: rtl/pq_wrap_count.sv
module pq_wrap_count
    import pq_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int DW    = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    apply,
    input  logic signed [DW-1:0]    delta,
    output logic signed [CNT_W-1:0] cnt
);

    localparam int CMAX = (1 << (CNT_W - 1)) - 1;
    localparam int CMIN = -(1 << (CNT_W - 1));

    int nxt_i;

    assign nxt_i = clamp_int(int'(cnt) + int'(delta), CMIN, CMAX);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (apply) cnt <= CNT_W'(nxt_i);
    end

endmodule

// File: rtl/pq_extended_quant.sv
module pq_extended_quant
    import pq_pkg::*;
#(
    parameter  int TAPS      = DEF_TAPS,
    parameter  int CNT_W     = DEF_CNT_W,
    parameter  int BLANK_CYC = DEF_BLANK_CYC,
    localparam int FINE_W    = $clog2(TAPS + 1),
    localparam int OUT_W     = CNT_W + FINE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TAPS-1:0]  taps,
    input  logic             phase_evt,
    input  logic             sample,
    output logic [OUT_W-1:0] code,
    output logic             code_vld
);

    localparam int DW = $clog2(BLANK_CYC + 3) + 1;

    wrap_e                    ev;
    logic                     apply;
    logic signed [DW-1:0]     delta;
    logic signed [CNT_W-1:0]  wrap_cnt;
    logic [FINE_W-1:0]        fine;

    pq_therm_dec #(.TAPS(TAPS), .FINE_W(FINE_W)) u_dec (
        .taps (taps),
        .fine (fine)
    );

    pq_wrap_detect #(.TAPS(TAPS)) u_det (
        .taps      (taps),
        .phase_evt (phase_evt),
        .ev        (ev)
    );

    pq_blank_gate #(.BLANK_CYC(BLANK_CYC), .DW(DW)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .sample (sample),
        .ev     (ev),
        .apply  (apply),
        .delta  (delta)
    );

    pq_wrap_count #(.CNT_W(CNT_W), .DW(DW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .apply (apply),
        .delta (delta),
        .cnt   (wrap_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code     <= '0;
            code_vld <= 1'b0;
        end else begin
            code_vld <= sample;
            if (sample) code <= {wrap_cnt, fine};
        end
    end

endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
    parameter int CNT_W     = 5,
    parameter int BLANK_CYC = 1,
    parameter int OUT_W     = 9
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sample,
    input logic [OUT_W-1:0]        code,
    input logic                    code_vld,
    input logic signed [CNT_W-1:0] cnt
);

    localparam logic signed [CNT_W-1:0] CTOP = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CBOT = {1'b1, {(CNT_W-1){1'b0}}};
    localparam int WW = $clog2(BLANK_CYC + 2);

    // Independent view of the window length
    logic [WW-1:0] wleft;
    always_ff @(posedge clk) begin
        if (rst)              wleft <= '0;
        else if (sample)      wleft <= WW'(BLANK_CYC);
        else if (wleft != '0) wleft <= wleft - 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (code == '0 && !code_vld));

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        sample |=> code_vld);

    // R9
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sample |=> !code_vld);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(code));

    // R10
    window_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (sample || wleft != '0) |=> $stable(cnt));

    // R8
    top_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CTOP) |=> (cnt != CBOT));

    // R8
    bottom_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CBOT) |=> (cnt != CTOP));

endmodule

bind pq_extended_quant pq_checker #(
    .CNT_W     (CNT_W),
    .BLANK_CYC (BLANK_CYC),
    .OUT_W     (OUT_W)
) u_pq_chk (
    .clk      (clk),
    .rst      (rst),
    .sample   (sample),
    .code     (code),
    .code_vld (code_vld),
    .cnt      (wrap_cnt)
);

// File: tb/test_pq_extended_quant.sv
`timescale 1ns/1ps
module test_pq_extended_quant;

    localparam logic [14:0] IDLE = 15'h00FF;
    localparam logic [14:0] ALLH = 15'h7FFF;
    localparam logic [14:0] ALLL = 15'h0000;

    // {bubble flag, taps, expected fine level}
    localparam logic [19:0] FINE_VEC [12] = '{
        {1'b0, 15'h0000, 4'd0},
        {1'b0, 15'h0001, 4'd1},
        {1'b0, 15'h0003, 4'd2},
        {1'b0, 15'h0007, 4'd3},
        {1'b0, 15'h007F, 4'd7},
        {1'b0, 15'h00FF, 4'd8},
        {1'b0, 15'h0FFF, 4'd12},
        {1'b0, 15'h3FFF, 4'd14},
        {1'b0, 15'h7FFF, 4'd15},
        {1'b1, 15'h0025, 4'd6},
        {1'b1, 15'h4001, 4'd15},
        {1'b1, 15'h0102, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] taps = IDLE;
    logic        phase_evt = 1'b0;
    logic        sample = 1'b0;
    logic [8:0]  code;
    logic        code_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pq_extended_quant i_pq_extended_quant (
        .clk       (clk),
        .rst       (rst),
        .taps      (taps),
        .phase_evt (phase_evt),
        .sample    (sample),
        .code      (code),
        .code_vld  (code_vld)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic cyc(input logic [14:0] t, input logic e, input logic s);
        taps = t; phase_evt = e; sample = s;
        @(negedge clk);
        phase_evt = 1'b0; sample = 1'b0;
    endtask

    task automatic settle();
        for (int k = 0; k < 3; k++) cyc(IDLE, 1'b0, 1'b0);
    endtask

    function automatic int cnt_of();
        logic signed [4:0] c;
        c = code[8:4];
        return int'(c);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc(IDLE, 1'b0, 1'b0);
        check("R1 code after reset", int'(code), 0);
        check("R1 valid after reset", int'(code_vld), 0);
        rst = 1'b0;
        settle();

        // Fine decode table; taps without a strobe leave the counter alone (R6)
        foreach (FINE_VEC[i]) begin
            cyc(FINE_VEC[i][18:4], 1'b0, 1'b1);
            check(FINE_VEC[i][19] ? "R3 bubble fine level" : "R2 thermometer fine level",
                  int'(code[3:0]), int'(FINE_VEC[i][3:0]));
            check("R6 counter idle", cnt_of(), 0);
            check("R9 valid after sample", int'(code_vld), 1);
            settle();
        end

        // R9: quiet and stable between samples
        check("R9 valid low between samples", int'(code_vld), 0);
        check("R9 code held", int'(code), int'({5'd0, 4'd9}));

        // R4 single up
        cyc(ALLH, 1'b1, 1'b0);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R4 up step", cnt_of(), 1);
        settle();

        // R5 two downs
        cyc(ALLL, 1'b1, 1'b0);
        cyc(ALLL, 1'b1, 1'b0);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R5 down steps", cnt_of(), -1);
        settle();

        // R6 strobes with mixed taps, levels without strobe
        cyc(IDLE, 1'b1, 1'b0);
        cyc(15'h0001, 1'b1, 1'b0);
        cyc(ALLH, 1'b0, 1'b0);
        cyc(ALLL, 1'b0, 1'b0);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R6 no wrap without both conditions", cnt_of(), -1);
        settle();

        // R7 burst of consecutive ups
        for (int k = 0; k < 5; k++) cyc(ALLH, 1'b1, 1'b0);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R7 burst counted", cnt_of(), 4);
        settle();

        // R8 saturation at both ends
        for (int k = 0; k < 20; k++) cyc(ALLH, 1'b1, 1'b0);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R8 top limit", cnt_of(), 15);
        settle();
        for (int k = 0; k < 40; k++) cyc(ALLL, 1'b1, 1'b0);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R8 bottom limit", cnt_of(), -16);
        settle();
        cyc(ALLH, 1'b1, 1'b0);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R8 step off bottom", cnt_of(), -15);
        settle();

        // R10 events inside the blanking window are deferred, not lost
        cyc(ALLH, 1'b1, 1'b1);
        check("R10 sample cycle shows old count", cnt_of(), -15);
        cyc(ALLH, 1'b1, 1'b0);
        cyc(IDLE, 1'b0, 1'b1);
        check("R10 still deferred in chained window", cnt_of(), -15);
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R10 deferred events applied", cnt_of(), -13);
        settle();

        // R1 reset mid-run clears counter
        rst = 1'b1;
        cyc(IDLE, 1'b0, 1'b0);
        check("R1 code cleared", int'(code), 0);
        rst = 1'b0;
        settle();
        cyc(IDLE, 1'b0, 1'b1);
        check("R1 counter cleared", cnt_of(), 0);
        settle();

        report();
        $finish;
    end

endmodule